// File: doc/BRIEF.md
# Split-Carry 64-bit Free-Running Timer

This block keeps a 64-bit time count that advances by one on every clock. The count is held as two half-width registers, each with its own adder, so no carry path is longer than one half. The low half increments every cycle. Its carry-out goes into a register and is added into the high half on the next clock. This keeps the critical path short. The cost is that, for one cycle after each low-half wrap, the plain concatenation of the halves is stale in its upper half.

Two 64-bit views leave the block. `timeRaw` is the plain concatenation, meant for a processor. A processor reads the count one half at a time through the word read port, so the one-cycle skew never reaches it. `timeSync` is meant for logic outside the processor. It takes its upper half straight from the high register and its lower half from a copy of the low register delayed by one cycle. Both halves of `timeSync` therefore always describe the same instant, and the value moves by exactly one per cycle, even across a wrap. A parameter can disable the timer, and then `timeSync` is held at zero. Either half can be loaded through a word-select write strobe.

Top module: `splitTimer`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, both halves, the pending carry and the delayed low copy are cleared, so `timeRaw` and `timeSync` read zero.
- R2: In every cycle without a low-half write, the low half increases by one, modulo 2^HALF_W.
- R3: When the low half wraps from all ones to zero, the high half rises by one on the following clock, not on the same one.
- R4: `timeRaw` is {high, low}. In the single cycle in which the low half has just become zero, it shows the old high half.
- R5: `timeSync` is {high, low as it was one cycle earlier}. With no write in the current or the previous cycle, it equals its previous value plus one, including across a low-to-high carry. Apart from that, `timeRaw` differs from `timeSync`+1 in exactly one cycle per low-half wrap.
- R6: `rdData` returns the low half of `timeRaw` when `rdSel`=0 and the high half when `rdSel`=1. The port has no register in its path.
- R7: A write with `wrSel`=0 loads `wrData` into the low half in place of that cycle's increment and clears the pending carry, so the high half does not advance on the next clock.
- R8: A write with `wrSel`=1 loads `wrData` into the high half and discards any carry that arrives in the same cycle.
- R9: With TIMER_EN=0, `timeSync` is zero in every cycle.
- R10: At HALF_W=8, the 16-bit count wraps from all ones to zero in `timeSync` within one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for one half |
| wrSel | input | 1 | Half to write: 0 low, 1 high |
| wrData | input | HALF_W | Value to load |
| rdSel | input | 1 | Half to read: 0 low, 1 high |
| rdData | output | HALF_W | Selected half of the raw count |
| timeRaw | output | 2*HALF_W | Concatenated count, may skew for one cycle |
| timeSync | output | 2*HALF_W | Realigned count for external logic |

## Verification
The bench builds three instances. The first uses the default 32-bit halves with the timer enabled; it is preset just below a low-half wrap so the 256-cycle approach and the carry hand-over can be watched cycle by cycle. The second sets TIMER_EN=0, which makes the forced-zero external view observable while its raw count keeps running. The third uses 8-bit halves, so a full 16-bit rollover from all ones to zero can be reached in a few cycles.

// File: rtl/splitTimerPkg.sv
package splitTimerPkg;
  typedef struct packed {
    logic loadLo;
    logic loadHi;
  } timerStrobes_t;
endpackage

// File: rtl/splitTimerCtrl.sv
module splitTimerCtrl
  import splitTimerPkg::*;
(
  input  logic          wrEn,
  input  logic          wrSel,
  output timerStrobes_t strb
);
  always_comb begin
    strb.loadLo = wrEn && !wrSel;
    strb.loadHi = wrEn && wrSel;
  end
endmodule

// File: rtl/splitTimerPath.sv
module splitTimerPath
  import splitTimerPkg::*;
#(
  parameter int HALF_W   = 32,
  parameter bit TIMER_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  timerStrobes_t       strb,
  input  logic [HALF_W-1:0]   wrData,
  output logic [HALF_W-1:0]   loWord,
  output logic [HALF_W-1:0]   hiWord,
  output logic [2*HALF_W-1:0] timeSync
);
  localparam int SUM_W = HALF_W + 1;
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [SUM_W-1:0]  loSum;
  logic [HALF_W-1:0] loDly;
  logic              carryQ;

  assign loSum = {1'b0, loWord} + SUM_W'(1);

  // low half with captured carry-out
  always_ff @(posedge clk) begin
    if (rst) begin
      loWord <= '0;
      carryQ <= 1'b0;
    end else if (strb.loadLo) begin
      loWord <= wrData;
      carryQ <= 1'b0;
    end else begin
      loWord <= loSum[HALF_W-1:0];
      carryQ <= loSum[HALF_W];
    end
  end

  // high half consumes the registered carry one clock late
  always_ff @(posedge clk) begin
    if (rst)              hiWord <= '0;
    else if (strb.loadHi) hiWord <= wrData;
    else                  hiWord <= hiWord + HALF_W'(carryQ);
  end

  always_ff @(posedge clk) begin
    if (rst) loDly <= '0;
    else     loDly <= loWord;
  end

  generate
    if (TIMER_EN) begin : g_on
      assign timeSync = {hiWord, loDly};
    end else begin : g_off
      assign timeSync = '0;
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (loWord == '0 && hiWord == '0 && !carryQ && loDly == '0));

  assert_low_step_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.loadLo |=> loWord == $past(loWord) + ONE);

  assert_carry_late_R3: assert property (@(posedge clk) disable iff (rst)
    (carryQ && !strb.loadHi) |=> hiWord == $past(hiWord) + ONE);

  assert_low_load_R7: assert property (@(posedge clk) disable iff (rst)
    strb.loadLo |=> (loWord == $past(wrData) && !carryQ));

  assert_high_load_R8: assert property (@(posedge clk) disable iff (rst)
    strb.loadHi |=> hiWord == $past(wrData));

  generate
    if (TIMER_EN) begin : g_chk
      assert_sync_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !strb.loadLo && !strb.loadHi &&
         !$past(strb.loadLo) && !$past(strb.loadHi))
        |=> timeSync == $past(timeSync) + (2*HALF_W)'(1));
    end
  endgenerate
endmodule

// File: rtl/splitTimer.sv
module splitTimer
  import splitTimerPkg::*;
#(
  parameter int HALF_W   = 32,
  parameter bit TIMER_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [HALF_W-1:0]   wrData,
  input  logic                rdSel,
  output logic [HALF_W-1:0]   rdData,
  output logic [2*HALF_W-1:0] timeRaw,
  output logic [2*HALF_W-1:0] timeSync
);
  timerStrobes_t     strb;
  logic [HALF_W-1:0] loWord;
  logic [HALF_W-1:0] hiWord;

  splitTimerCtrl u_ctrl (
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .strb  (strb)
  );

  splitTimerPath #(.HALF_W(HALF_W), .TIMER_EN(TIMER_EN)) u_path (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (wrData),
    .loWord   (loWord),
    .hiWord   (hiWord),
    .timeSync (timeSync)
  );

  assign timeRaw = {hiWord, loWord};
  assign rdData  = rdSel ? hiWord : loWord;
endmodule

// File: tb/splitTimer_bench.sv
module splitTimer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] timeRaw, timeSync, offRaw, offSync;
  logic [31:0] offRd;
  logic nWrEn = 1'b0, nWrSel = 1'b0;
  logic [7:0] nWrData = '0, nRd;
  logic [15:0] nRaw, nSync;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  splitTimer u_splitTimer (.clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .timeRaw(timeRaw), .timeSync(timeSync));

  splitTimer #(.TIMER_EN(1'b0)) u_splitTimerOff (.clk(clk), .rst(rst), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(offRd), .timeRaw(offRaw),
    .timeSync(offSync));

  splitTimer #(.HALF_W(8)) u_splitTimerNarrow (.clk(clk), .rst(rst), .wrEn(nWrEn),
    .wrSel(nWrSel), .wrData(nWrData), .rdSel(1'b0), .rdData(nRd), .timeRaw(nRaw),
    .timeSync(nSync));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wrSel = sel; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1; tick(); tick();
    check("R1 raw", timeRaw, 64'd0);
    check("R1 sync", timeSync, 64'd0);
    rst = 1'b0;
    tick();
    check("R2 first step", timeRaw, 64'd1);
  endtask

  task automatic testWrap();
    logic [63:0] prevSync;
    int skew = 0;
    wr(1'b1, 32'd0);
    wr(1'b0, 32'hFFFF_FF00);
    tick();
    prevSync = timeSync;
    for (int k = 2; k <= 300; k++) begin
      tick();
      check("R5 step", timeSync, prevSync + 64'd1);
      if (timeRaw !== timeSync + 64'd1) skew++;
      if (k == 10)  check("R2 low count", timeRaw, 64'h0000_0000_FFFF_FF0A);
      if (k == 256) check("R4 stale high", timeRaw, 64'h0000_0000_0000_0000);
      if (k == 256) check("R5 sync before", timeSync, 64'h0000_0000_FFFF_FFFF);
      if (k == 257) check("R3 high late", timeRaw, 64'h0000_0001_0000_0001);
      if (k == 257) check("R5 sync after", timeSync, 64'h0000_0001_0000_0000);
      prevSync = timeSync;
    end
    check("R5 skew count", 64'(skew), 64'd1);
  endtask

  task automatic testLowWrite();
    logic [31:0] hiBefore;
    wr(1'b0, 32'hFFFF_FFFE);
    tick();
    hiBefore = timeRaw[63:32];
    wr(1'b0, 32'd5);
    check("R7 load no inc", 64'(timeRaw[31:0]), 64'd5);
    tick();
    check("R7 carry cleared", timeRaw, {hiBefore, 32'd6});
  endtask

  task automatic testHighWrite();
    wr(1'b0, 32'hFFFF_FFFE);
    tick(); tick();
    wr(1'b1, 32'h55);
    check("R8 carry dropped", timeRaw, 64'h0000_0055_0000_0001);
    tick();
    check("R8 holds", 64'(timeRaw[63:32]), 64'h55);
  endtask

  task automatic testRead();
    wr(1'b1, 32'hABCD_1234);
    rdSel = 1'b1; #1;
    check("R6 high read", 64'(rdData), 64'hABCD_1234);
    rdSel = 1'b0; #1;
    check("R6 low read", 64'(rdData), 64'(timeRaw[31:0]));
  endtask

  task automatic testOff();
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R9 sync zero", offSync, 64'd0);
    end
    check("R9 raw runs", 64'(offRaw != 64'd0), 64'd1);
  endtask

  task automatic testNarrow();
    nWrSel = 1'b1; nWrData = 8'hFF; nWrEn = 1'b1; tick();
    nWrSel = 1'b0; nWrData = 8'hFE; tick();
    nWrEn = 1'b0;
    tick();
    tick();
    check("R10 all ones", 64'(nSync), 64'hFFFF);
    tick();
    check("R10 rolled", 64'(nSync), 64'h0000);
    check("R10 raw", 64'(nRaw), 64'h0001);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testWrap();
    testLowWrite();
    testHighWrite();
    testRead();
    testOff();
    testNarrow();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule